// File: doc/BRIEF.md
# Grouped Interrupt Aggregator with Deferred Delivery

This block gathers nine banks of 32 source lines into nine output interrupt lines, one per bank. Firmware reaches it over a plain 32-bit register bus. Each bank has two words. The first is a control word that grants sources and masks them. The second is a flag word that reports which granted sources produced an event. Firmware acknowledges flags one bit at a time by writing ones to the flag word.

A source event is a rising edge on a line, sampled on the clock. An event is not always delivered at once. If the bank is still being serviced (its flag word is nonzero) or is masked, the event is parked in a hidden holding set. The holding set is moved into the flag word automatically when firmware acknowledges the last flag. The output line of a bank stays high while there is work to report. It drops only when a normal acknowledge empties the flag word and nothing is held.

The control word has two uses, chosen by what is already granted. A write that grants any new source adds it to the granted set, and the set never shrinks. A write that grants nothing new is read as a mask operation on the bits that differ from the previous control value.

Top module: `grp_irq_agg`

## Requirements
- R1: After synchronous reset every output line is 0 and every control and flag word reads 0.
- R2: Bank g decodes as follows. Address bits [15:12] must be 1 and bits [11:8] give g. Bits [7:0] = 0x00 select the control word and 0x04 select the flag word. When an event arrives in a bank whose flag word and mask are both zero, the flag word is loaded with (rising lines AND granted set) and output bit g is high in the next cycle.
- R3: A line that stays high causes no further event, and a rising line that is not granted causes none.
- R4: Lines that rise in the same cycle are captured together in one flag value.
- R5: An event in a bank whose flag word is nonzero leaves the flag word unchanged and adds the event bits to the holding set.
- R6: Writing ones to the flag word clears those bits. If bits remain set, the output stays high.
- R7: A flag write (not all ones) that leaves the flag word at zero while the holding set is nonzero copies the holding set into the flag word, empties the holding set and keeps the output high.
- R8: A flag write (not all ones) that leaves the flag word at zero while the holding set is empty drives the output low.
- R9: A flag write of 0xFFFFFFFF clears the flag word and changes neither the output nor the holding set. A later flag write of 0 delivers the held bits.
- R10: A control write that adds new sources ORs them into the granted set and stores the written value as the readable control word. Granted sources are never removed except by reset.
- R11: A control write that adds no new source stores the written value and computes d = old control word XOR data. If (d AND data) is nonzero, the d bits are unmasked; otherwise the d bits are masked. While any mask bit is set, events go to the holding set.
- R12: A flag write and an event in the same bank and cycle apply the write first, then evaluate the event against the updated flag word.
- R13: Read data appears one cycle after rd_en and is 0 otherwise. Reads and writes to addresses that do not decode (bank index 9 or higher, or any other offset) return 0 or are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 16 | Byte address of the 32-bit word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after rd_en |
| src_lines | input | 288 | Source lines; bank g uses bits [32g+31:32g] |
| irq_out | output | 9 | One interrupt line per bank |

## Verification
The event path is tried four ways. A single pulse on an idle bank checks direct delivery. A multi-line pulse mixed with ungranted lines checks capture of several lines at once and the grant filter. A line held high checks that only rising edges count. Pulses into a bank that is busy or masked check that events are held rather than lost or delivered early. The acknowledge sequences are chosen to separate three outcomes: a partial clear, a drain that re-delivers held bits, and a drain that drops the line. A same-cycle write and event, plus an all-ones initialisation followed by a zero write, separate the write-then-event order and the held-set rules from simpler orderings.

// File: rtl/gia_pkg.sv
package gia_pkg;

    localparam int NUM_GRP   = 9;
    localparam int SRC_W     = 32;
    localparam int ADDR_W    = 16;
    localparam int GRP_IDX_W = 4;

    localparam logic [3:0] WIN_PAGE = 4'h1;
    localparam logic [7:0] OFS_CTL  = 8'h00;
    localparam logic [7:0] OFS_FLAG = 8'h04;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_CTL  = 2'd1,
        ACC_FLAG = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e             kind;
        logic [GRP_IDX_W-1:0]  grp;
    } acc_dec_t;

    function automatic acc_dec_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int                ngrp);
        acc_dec_t d;
        d.kind = ACC_NONE;
        d.grp  = a[11:8];
        if (a[15:12] == WIN_PAGE && int'(a[11:8]) < ngrp) begin
            if (a[7:0] == OFS_CTL)
                d.kind = ACC_CTL;
            else if (a[7:0] == OFS_FLAG)
                d.kind = ACC_FLAG;
        end
        return d;
    endfunction

endpackage

// File: rtl/gia_ctl.sv
module gia_ctl #(
    parameter int SRC_W = gia_pkg::SRC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [SRC_W-1:0] wdata,
    output logic [SRC_W-1:0] ctl_word,
    output logic [SRC_W-1:0] grant,
    output logic [SRC_W-1:0] mask
);

    logic [SRC_W-1:0] ctl_n, grant_n, mask_n, diff;

    always_comb begin
        ctl_n   = ctl_word;
        grant_n = grant;
        mask_n  = mask;
        diff    = ctl_word ^ wdata;
        if (ctl_wr) begin
            if (wdata == '0 && grant == '0) begin
                ctl_n = wdata;
            end else if ((grant | wdata) != grant) begin
                grant_n = grant | wdata;
                ctl_n   = wdata;
            end else begin
                if ((diff & wdata) != '0)
                    mask_n = mask & ~diff;
                else
                    mask_n = mask | diff;
                ctl_n = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_word <= '0;
            grant    <= '0;
            mask     <= '0;
        end else begin
            ctl_word <= ctl_n;
            grant    <= grant_n;
            mask     <= mask_n;
        end
    end

    // R10: the granted set only grows
    a_r10_grant_monotonic: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((grant & $past(grant)) == $past(grant)));

    // R11: the mask moves only on a control write
    a_r11_mask_needs_write: assert property (@(posedge clk) disable iff (rst)
        !ctl_wr |=> $stable(mask));

endmodule

// File: rtl/gia_evt.sv
module gia_evt #(
    parameter int SRC_W = gia_pkg::SRC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] src,
    input  logic [SRC_W-1:0] grant,
    input  logic [SRC_W-1:0] mask,
    input  logic             flag_wr,
    input  logic [SRC_W-1:0] wdata,
    output logic [SRC_W-1:0] flag_word,
    output logic             irq
);

    logic [SRC_W-1:0] src_q, held, rise, sel;
    logic [SRC_W-1:0] flag_n, held_n;
    logic             irq_n;

    assign rise = src & ~src_q;
    assign sel  = rise & grant;

    always_comb begin
        flag_n = flag_word;
        held_n = held;
        irq_n  = irq;
        // acknowledge first
        if (flag_wr) begin
            flag_n = flag_word & ~wdata;
            if (wdata != '1 && flag_n == '0) begin
                if (held != '0) begin
                    flag_n = held;
                    held_n = '0;
                    irq_n  = 1'b1;
                end else begin
                    irq_n = 1'b0;
                end
            end
        end
        // then the event against the updated flag word
        if (sel != '0) begin
            if (mask != '0 || flag_n != '0) begin
                held_n = held_n | sel;
            end else begin
                flag_n = sel;
                irq_n  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q     <= '0;
            held      <= '0;
            flag_word <= '0;
            irq       <= 1'b0;
        end else begin
            src_q     <= src;
            held      <= held_n;
            flag_word <= flag_n;
            irq       <= irq_n;
        end
    end

    // R2: a nonzero flag word always comes with the output high
    a_r2_flag_implies_irq: assert property (@(posedge clk) disable iff (rst)
        (flag_word != '0) |-> irq);

    // R5: without an acknowledge a nonzero flag word holds its value
    a_r5_busy_flag_stable: assert property (@(posedge clk) disable iff (rst)
        (!flag_wr && flag_word != '0) |=> $stable(flag_word));

    // R8: the output only falls after an acknowledge write
    a_r8_fall_needs_ack: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(flag_wr));

    // R11: a masked idle bank stays idle until an acknowledge
    a_r11_masked_defers: assert property (@(posedge clk) disable iff (rst)
        (mask != '0 && !flag_wr && flag_word == '0) |=> (flag_word == '0));

    // R6: a partial clear keeps the output high
    a_r6_partial_keeps_irq: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && wdata != '1 && (flag_word & ~wdata) != '0) |=> irq);

endmodule

// File: rtl/grp_irq_agg.sv
module grp_irq_agg #(
    parameter int NUM_GRP = gia_pkg::NUM_GRP,
    parameter int SRC_W   = gia_pkg::SRC_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [gia_pkg::ADDR_W-1:0] addr,
    input  logic [SRC_W-1:0]           wdata,
    output logic [SRC_W-1:0]           rdata,
    input  logic [NUM_GRP*SRC_W-1:0]   src_lines,
    output logic [NUM_GRP-1:0]         irq_out
);
    import gia_pkg::*;

    acc_dec_t          dec;
    logic [SRC_W-1:0]  ctl_words  [NUM_GRP];
    logic [SRC_W-1:0]  flag_words [NUM_GRP];
    logic [SRC_W-1:0]  rd_val;

    assign dec = decode_addr(addr, NUM_GRP);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_bank
        logic             ctl_wr, flag_wr;
        logic [SRC_W-1:0] grant, mask;

        assign ctl_wr  = wr_en && dec.kind == ACC_CTL  && dec.grp == GRP_IDX_W'(g);
        assign flag_wr = wr_en && dec.kind == ACC_FLAG && dec.grp == GRP_IDX_W'(g);

        gia_ctl #(.SRC_W(SRC_W)) u_ctl (
            .clk      (clk),
            .rst      (rst),
            .ctl_wr   (ctl_wr),
            .wdata    (wdata),
            .ctl_word (ctl_words[g]),
            .grant    (grant),
            .mask     (mask)
        );

        gia_evt #(.SRC_W(SRC_W)) u_evt (
            .clk       (clk),
            .rst       (rst),
            .src       (src_lines[g*SRC_W +: SRC_W]),
            .grant     (grant),
            .mask      (mask),
            .flag_wr   (flag_wr),
            .wdata     (wdata),
            .flag_word (flag_words[g]),
            .irq       (irq_out[g])
        );
    end

    always_comb begin
        unique case (dec.kind)
            ACC_CTL:  rd_val = ctl_words[dec.grp];
            ACC_FLAG: rd_val = flag_words[dec.grp];
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_val;
        else
            rdata <= '0;
    end

    // R13: no read, no data
    a_r13_rdata_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rdata == '0));

    // R13: undecoded reads return zero
    a_r13_bad_addr_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[15:12] != 4'h1) |=> (rdata == '0));

endmodule

// File: tb/grp_irq_agg_tb_top.sv
`timescale 1ns/1ps
module grp_irq_agg_tb_top;

    localparam int NG = 9;
    localparam int SW = 32;

    logic            clk = 1'b0;
    logic            rst;
    logic            wr_en, rd_en;
    logic [15:0]     addr;
    logic [SW-1:0]   wdata;
    logic [SW-1:0]   rdata;
    logic [NG*SW-1:0] src;
    logic [NG-1:0]   irq_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    grp_irq_agg dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .src_lines(src), .irq_out(irq_out)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired act=%0d exp<=20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [15:0] ctl_a(int g);
        return 16'h1000 + 16'(g * 256);
    endfunction
    function automatic logic [15:0] flag_a(int g);
        return 16'h1004 + 16'(g * 256);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(int g, logic [31:0] bits);
        @(negedge clk);
        src[g*SW +: SW] = bits;
        @(negedge clk);
        src[g*SW +: SW] = '0;
    endtask

    task automatic rd_chk(string tag, logic [15:0] a, logic [31:0] exp);
        logic [31:0] d;
        bus_rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic t_reset();
        chk("R1 irq_out after reset", 32'(irq_out), 32'h0);
        rd_chk("R1 ctl bank0", ctl_a(0), 32'h0);
        rd_chk("R1 flag bank8", flag_a(8), 32'h0);
    endtask

    task automatic t_basic();
        bus_wr(ctl_a(2), 32'h0000_00F0);
        rd_chk("R10 ctl readback", ctl_a(2), 32'h0000_00F0);
        pulse(2, 32'h0000_0031);
        chk("R2 irq bank2 high", 32'(irq_out), 32'h0000_0004);
        rd_chk("R4 R3 flag captures granted lines together", flag_a(2), 32'h0000_0030);
        bus_wr(flag_a(2), 32'h0000_0030);
        chk("R8 drain drops irq", 32'(irq_out), 32'h0);
    endtask

    task automatic t_level();
        bus_wr(ctl_a(5), 32'h1);
        @(negedge clk); src[5*SW] = 1'b1;
        @(negedge clk);
        chk("R2 bank5 event", 32'(irq_out), 32'h0000_0020);
        bus_wr(flag_a(5), 32'h1);
        chk("R8 bank5 low", 32'(irq_out), 32'h0);
        repeat (3) @(negedge clk);
        chk("R3 held line no new event", 32'(irq_out), 32'h0);
        rd_chk("R3 flag stays zero", flag_a(5), 32'h0);
        src[5*SW] = 1'b0;
    endtask

    task automatic t_pending();
        bus_wr(ctl_a(3), 32'hFF);
        pulse(3, 32'h01);
        pulse(3, 32'h06);
        rd_chk("R5 busy flag unchanged", flag_a(3), 32'h01);
        bus_wr(flag_a(3), 32'h01);
        chk("R7 irq kept on redelivery", 32'(irq_out), 32'h0000_0008);
        rd_chk("R7 held bits delivered", flag_a(3), 32'h06);
        bus_wr(flag_a(3), 32'h02);
        chk("R6 partial clear keeps irq", 32'(irq_out), 32'h0000_0008);
        rd_chk("R6 remaining flag", flag_a(3), 32'h04);
        bus_wr(flag_a(3), 32'h04);
        chk("R8 holding set emptied, irq low", 32'(irq_out), 32'h0);
    endtask

    task automatic t_init();
        bus_wr(ctl_a(8), 32'h3);
        pulse(8, 32'h1);
        pulse(8, 32'h2);
        bus_wr(flag_a(8), 32'hFFFF_FFFF);
        chk("R9 init write keeps irq", 32'(irq_out), 32'h0000_0100);
        rd_chk("R9 init write clears flag", flag_a(8), 32'h0);
        bus_wr(flag_a(8), 32'h0);
        rd_chk("R9 zero write delivers held", flag_a(8), 32'h2);
        bus_wr(flag_a(8), 32'h2);
        chk("R8 bank8 low", 32'(irq_out), 32'h0);
    endtask

    task automatic t_mask();
        bus_wr(ctl_a(4), 32'hF);
        bus_wr(ctl_a(4), 32'h3);
        rd_chk("R11 ctl stores data", ctl_a(4), 32'h3);
        pulse(4, 32'h8);
        chk("R11 masked event not delivered", 32'(irq_out), 32'h0);
        rd_chk("R11 masked flag zero", flag_a(4), 32'h0);
        bus_wr(ctl_a(4), 32'hF);
        pulse(4, 32'h1);
        rd_chk("R11 unmasked event delivered", flag_a(4), 32'h1);
        bus_wr(flag_a(4), 32'h1);
        rd_chk("R10 grant kept bit3, held bit delivered", flag_a(4), 32'h8);
        chk("R7 bank4 high", 32'(irq_out), 32'h0000_0010);
        bus_wr(flag_a(4), 32'h8);
        chk("R8 bank4 low", 32'(irq_out), 32'h0);
    endtask

    task automatic t_same_cycle();
        bus_wr(ctl_a(1), 32'h3);
        pulse(1, 32'h1);
        @(negedge clk);
        wr_en = 1'b1; addr = flag_a(1); wdata = 32'h1;
        src[1*SW +: SW] = 32'h2;
        @(negedge clk);
        wr_en = 1'b0; src[1*SW +: SW] = '0;
        chk("R12 irq high after write+event", 32'(irq_out), 32'h0000_0002);
        rd_chk("R12 event loaded after clear", flag_a(1), 32'h2);
        bus_wr(flag_a(1), 32'h2);
        chk("R12 drained", 32'(irq_out), 32'h0);
    endtask

    task automatic t_decode();
        bus_wr(16'h1900, 32'hFFFF_FFFF);
        rd_chk("R13 bank9 reads zero", 16'h1900, 32'h0);
        rd_chk("R13 misaligned reads zero", 16'h1202, 32'h0);
        rd_chk("R13 other offset reads zero", 16'h1008, 32'h0);
        rd_chk("R13 outside window reads zero", 16'h0000, 32'h0);
        rd_chk("R13 bank2 ctl unaffected", ctl_a(2), 32'h0000_00F0);
        chk("R13 no irq from ignored write", 32'(irq_out), 32'h0);
        @(negedge clk);
        chk("R13 rdata idle zero", rdata, 32'h0);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; src = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_level();
        t_pending();
        t_init();
        t_mask();
        t_same_cycle();
        t_decode();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule